// File: doc/BRIEF.md
# Granule protection check unit

This block decides, for every physical-address access a requester issues, whether the access may proceed. It holds a small table of per-granule attributes in local registers. Each 4 KB granule inside a programmable window is described by one table entry. That entry can do one of three things: bind the granule to a single physical address space (PAS), refuse every access, or admit any PAS. When it admits any PAS, the transaction goes through unchanged and the target completer does its own filtering. Accesses outside the window are judged by one programmable default attribute instead of a table entry.

The requester presents a valid strobe, a physical address and the transaction's PAS tag. One cycle later the unit reports pass or fault together with a reason code. A simple write port loads the table entries, the window base, the window length and the default attribute.

Top module: `gpc_unit`

## Requirements
- R1: `res_valid_o` is high in exactly the cycle after a cycle in which `req_valid_i` is high. In every other cycle it is low. `res_fault_o` and `res_reason_o` keep their last values until the next request.
- R2: PAS tags are Secure=00, Non-secure=01, Root=10 and Realm=11. An entry code `1pp` binds its granule to PAS `pp`. A request whose tag equals `pp` passes, with reason 0.
- R3: A request to a granule whose entry is `1pp` faults with reason 1 when its tag differs from `pp`.
- R4: Entry codes 000, 001 and 010 mean no access. Every PAS faults on them with reason 2.
- R5: Entry code 011 admits every PAS. The request passes with reason 0.
- R6: Let g be the address with its low 12 bits dropped. When base <= g < base+limit, the unit uses entry g-base.
- R7: Outside the window the default attribute is decoded with the rules of R2 to R5. If the result is a fault it carries reason 3; if it is a pass, reason 0.
- R8: The write port works as follows. Writing `cfg_addr_i` with its top bit 0 loads the entry whose number is in the low bits, taken from `cfg_wdata_i[2:0]`. With the top bit 1, low value 0 loads the window base as a granule number, 1 loads the limit as a granule count, and 2 loads the default attribute. Other low values are ignored. A write takes effect in the next cycle, so a request in the same cycle is judged with the old value.
- R9: A limit written above `NUM_ENTRIES` is stored as `NUM_ENTRIES`.
- R10: After reset every entry is 000, base is 0, limit is 0 and the default is 000. All result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request strobe |
| req_addr_i | input | ADDR_W | Physical address of the access |
| req_pas_i | input | 2 | PAS tag of the transaction |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | IDX_W+1 | Register select |
| cfg_wdata_i | input | CFG_DW | Register write data |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| res_fault_o | output | 1 | 1 = access refused |
| res_reason_o | output | 2 | 0 pass, 1 PAS mismatch, 2 no access, 3 default attribute fault |

## Verification
The same cycle can carry both a register write and a check that depends on the register being written. The bench provokes this by writing a new code into the table entry of a granule while a request to that granule is presented. The result of that request must follow the old entry. A second request one cycle later must follow the new code. The same pairing is used with the limit register, where a request on the window edge is presented while the limit is rewritten.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  localparam int GRANULE_SHIFT = 12;

  typedef enum logic [1:0] {
    PAS_SEC   = 2'b00,
    PAS_NSEC  = 2'b01,
    PAS_ROOT  = 2'b10,
    PAS_REALM = 2'b11
  } pas_e;

  localparam logic [2:0] ATTR_ANY = 3'b011;

  typedef enum logic [1:0] {
    RSN_NONE     = 2'd0,
    RSN_MISMATCH = 2'd1,
    RSN_NOACCESS = 2'd2,
    RSN_DEFAULT  = 2'd3
  } reason_e;

  typedef struct packed {
    logic    fault;
    reason_e reason;
  } verdict_t;
endpackage

// File: rtl/gpc_cfg_regs.sv
module gpc_cfg_regs #(
  parameter int NUM_ENTRIES = 16,
  parameter int GW          = 28,
  parameter int CFG_DW      = 32,
  parameter int IDX_W       = 4,
  parameter int LIM_W       = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [IDX_W:0]                cfg_addr_i,
  input  logic [CFG_DW-1:0]             cfg_wdata_i,
  output logic [NUM_ENTRIES-1:0][2:0]   entries_o,
  output logic [GW-1:0]                 base_o,
  output logic [LIM_W-1:0]              limit_o,
  output logic [2:0]                    dflt_o
);
  localparam logic [CFG_DW-1:0] LIM_MAX = CFG_DW'(NUM_ENTRIES);

  logic ctl_sel;
  logic [IDX_W-1:0] sub_sel;
  assign ctl_sel = cfg_addr_i[IDX_W];
  assign sub_sel = cfg_addr_i[IDX_W-1:0];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) entries_o[e] <= 3'b000;
      else if (cfg_we_i && !ctl_sel && sub_sel == IDX_W'(e))
        entries_o[e] <= cfg_wdata_i[2:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      limit_o <= '0;
      dflt_o  <= 3'b000;
    end else if (cfg_we_i && ctl_sel) begin
      case (sub_sel)
        IDX_W'(0): base_o <= cfg_wdata_i[GW-1:0];
        IDX_W'(1): limit_o <= (cfg_wdata_i > LIM_MAX) ? LIM_W'(NUM_ENTRIES)
                                                      : cfg_wdata_i[LIM_W-1:0];
        IDX_W'(2): dflt_o <= cfg_wdata_i[2:0];
        default: ;
      endcase
    end
  end

  p_limit_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(limit_o) <= NUM_ENTRIES);

  p_entry_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !ctl_sel && 32'(sub_sel) < NUM_ENTRIES) |=>
      entries_o[$past(sub_sel)] == $past(cfg_wdata_i[2:0]));

  p_default_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && ctl_sel && sub_sel == IDX_W'(2)) |=> dflt_o == $past(cfg_wdata_i[2:0]));
endmodule

// File: rtl/gpc_window.sv
module gpc_window #(
  parameter int NUM_ENTRIES = 16,
  parameter int GW          = 28,
  parameter int IDX_W       = 4,
  parameter int LIM_W       = 5
) (
  input  logic [GW-1:0]                gran_i,
  input  logic [NUM_ENTRIES-1:0][2:0]  entries_i,
  input  logic [GW-1:0]                base_i,
  input  logic [LIM_W-1:0]             limit_i,
  input  logic [2:0]                   dflt_i,
  output logic                         in_win_o,
  output logic [2:0]                   attr_o
);
  logic [GW-1:0]    offset;
  logic [IDX_W-1:0] idx;
  logic             above_base;

  always_comb begin
    above_base = gran_i >= base_i;
    offset     = gran_i - base_i;
    in_win_o   = above_base && (offset < GW'(limit_i));
    idx        = offset[IDX_W-1:0];
    attr_o     = in_win_o ? entries_i[idx] : dflt_i;
  end
endmodule

// File: rtl/gpc_decide.sv
module gpc_decide
  import gpc_pkg::*;
(
  input  logic [2:0] attr_i,
  input  logic [1:0] pas_i,
  input  logic       outside_i,
  output verdict_t   verdict_o
);
  reason_e raw;

  always_comb begin
    if (attr_i == ATTR_ANY)     raw = RSN_NONE;
    else if (!attr_i[2])        raw = RSN_NOACCESS;
    else if (attr_i[1:0] != pas_i) raw = RSN_MISMATCH;
    else                        raw = RSN_NONE;

    verdict_o.fault  = (raw != RSN_NONE);
    verdict_o.reason = (verdict_o.fault && outside_i) ? RSN_DEFAULT : raw;
  end
endmodule

// File: rtl/gpc_unit.sv
module gpc_unit
  import gpc_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 40,
  parameter int CFG_DW      = 32,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int GW         = ADDR_W - GRANULE_SHIFT,
  localparam int LIM_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_pas_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W:0]    cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic              res_valid_o,
  output logic              res_fault_o,
  output logic [1:0]        res_reason_o
);
  logic [NUM_ENTRIES-1:0][2:0] entries;
  logic [GW-1:0]               base;
  logic [LIM_W-1:0]            limit;
  logic [2:0]                  dflt;
  logic                        in_win;
  logic [2:0]                  attr;
  verdict_t                    verdict;

  gpc_cfg_regs #(
    .NUM_ENTRIES(NUM_ENTRIES), .GW(GW), .CFG_DW(CFG_DW),
    .IDX_W(IDX_W), .LIM_W(LIM_W)
  ) i_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .entries_o(entries), .base_o(base), .limit_o(limit), .dflt_o(dflt)
  );

  gpc_window #(
    .NUM_ENTRIES(NUM_ENTRIES), .GW(GW), .IDX_W(IDX_W), .LIM_W(LIM_W)
  ) i_window (
    .gran_i(req_addr_i[ADDR_W-1:GRANULE_SHIFT]), .entries_i(entries),
    .base_i(base), .limit_i(limit), .dflt_i(dflt),
    .in_win_o(in_win), .attr_o(attr)
  );

  gpc_decide i_decide (
    .attr_i(attr), .pas_i(req_pas_i), .outside_i(!in_win), .verdict_o(verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_fault_o  <= 1'b0;
      res_reason_o <= 2'd0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        res_fault_o  <= verdict.fault;
        res_reason_o <= verdict.reason;
      end
    end
  end

  p_valid_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  p_idle_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(res_fault_o) && $stable(res_reason_o)));
  p_any_passes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && attr == ATTR_ANY) |=> !res_fault_o);
  p_noaccess_faults_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !attr[2] && attr != ATTR_ANY) |=> res_fault_o);
  p_default_outside_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && res_valid_o == res_valid_o && in_win) |=> res_reason_o != 2'd3);
  p_pass_no_reason_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_fault_o) |-> res_reason_o == 2'd0);
endmodule

// File: tb/test_gpc_unit.sv
module test_gpc_unit;
  localparam int ADDR_W = 40;
  localparam int AW     = 5;

  typedef struct packed {
    logic [27:0] gran;
    logic [1:0]  pas;
    logic        fault;
    logic [1:0]  reason;
  } vec_t;

  // window base 0x100, limit 8, default 101 (Non-secure only)
  localparam vec_t VECS [15] = '{
    '{28'h100, 2'b00, 1'b0, 2'd0},  // R2 Secure granule, Secure tag
    '{28'h100, 2'b01, 1'b1, 2'd1},  // R3 mismatch
    '{28'h101, 2'b01, 1'b0, 2'd0},  // R2
    '{28'h102, 2'b10, 1'b0, 2'd0},  // R2 Root
    '{28'h103, 2'b11, 1'b0, 2'd0},  // R2 Realm
    '{28'h103, 2'b00, 1'b1, 2'd1},  // R3
    '{28'h104, 2'b11, 1'b0, 2'd0},  // R5 any PAS
    '{28'h104, 2'b00, 1'b0, 2'd0},  // R5
    '{28'h105, 2'b01, 1'b1, 2'd2},  // R4 code 000
    '{28'h106, 2'b10, 1'b1, 2'd2},  // R4 code 010
    '{28'h107, 2'b01, 1'b0, 2'd0},  // R6 last granule in window
    '{28'h108, 2'b00, 1'b1, 2'd3},  // R7 beyond limit, default faults
    '{28'h108, 2'b01, 1'b0, 2'd0},  // R7 default passes
    '{28'h0ff, 2'b11, 1'b1, 2'd3},  // R7 below base
    '{28'h0ff, 2'b01, 1'b0, 2'd0}   // R7
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0]        req_pas_i = '0;
  logic              cfg_we_i = 1'b0;
  logic [AW-1:0]     cfg_addr_i = '0;
  logic [31:0]       cfg_wdata_i = '0;
  logic              res_valid_o, res_fault_o;
  logic [1:0]        res_reason_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  gpc_unit i_gpc_unit (.*);

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [AW-1:0] a, logic [31:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // drives a request at a negedge, checks valid/fault/reason at the next negedge
  task automatic request(string tag, logic [27:0] g, logic [1:0] p,
                         logic f, logic [1:0] r);
    req_valid_i = 1'b1; req_addr_i = {g, 12'h3a5}; req_pas_i = p;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(tag, {res_valid_o, res_fault_o, res_reason_o}, {1'b1, f, r});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset outputs", {1'b0, res_valid_o, res_fault_o, res_reason_o}, 4'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    request("R10 reset default no access", 28'h000, 2'b01, 1'b1, 2'd3);

    // table setup
    cfg_write(5'h10, 32'h100);
    cfg_write(5'h11, 32'd8);
    cfg_write(5'h12, 32'h5);
    cfg_write(5'h00, 32'h4);
    cfg_write(5'h01, 32'h5);
    cfg_write(5'h02, 32'h6);
    cfg_write(5'h03, 32'h7);
    cfg_write(5'h04, 32'h3);
    cfg_write(5'h05, 32'h0);
    cfg_write(5'h06, 32'h2);
    cfg_write(5'h07, 32'h5);
    cfg_write(5'h08, 32'h3);

    for (int i = 0; i < 15; i++)
      request($sformatf("R2-7 vector %0d", i), VECS[i].gran, VECS[i].pas,
              VECS[i].fault, VECS[i].reason);

    // R1: idle cycle drops valid, holds fault and reason
    request("R1 setup", 28'h105, 2'b00, 1'b1, 2'd2);
    @(negedge clk_i);
    check("R1 hold", {res_valid_o, res_fault_o, res_reason_o}, {1'b0, 1'b1, 2'd2});

    // R8: write and request to same entry in one cycle
    cfg_we_i = 1'b1; cfg_addr_i = 5'h00; cfg_wdata_i = 32'h5;
    request("R8 old entry used", 28'h100, 2'b00, 1'b0, 2'd0);
    cfg_we_i = 1'b0;
    request("R8 new entry used", 28'h100, 2'b00, 1'b1, 2'd1);

    // R8: limit rewrite in the same cycle as an edge request
    cfg_we_i = 1'b1; cfg_addr_i = 5'h11; cfg_wdata_i = 32'd9;
    request("R8 old limit used", 28'h108, 2'b00, 1'b1, 2'd3);
    cfg_we_i = 1'b0;
    request("R8 new limit used", 28'h108, 2'b00, 1'b0, 2'd0);

    // R8: unused control address ignored, default stays Non-secure only
    cfg_write(5'h13, 32'h3);
    request("R8 ignored address", 28'h200, 2'b00, 1'b1, 2'd3);

    // R9: limit clamp to 16, entry 15 reset 000 now inside window
    cfg_write(5'h11, 32'd100);
    request("R9 clamp inside", 28'h10f, 2'b11, 1'b1, 2'd2);
    request("R9 clamp outside", 28'h110, 2'b11, 1'b1, 2'd3);

    // R7: default set to any PAS
    cfg_write(5'h12, 32'h3);
    request("R7 default any", 28'h0ff, 2'b10, 1'b0, 2'd0);

    // R6: base moved, entry 0 now covers granule 0x300
    cfg_write(5'h10, 32'h300);
    request("R6 rebased entry", 28'h300, 2'b01, 1'b0, 2'd0);
    request("R6 rebased mismatch", 28'h300, 2'b10, 1'b1, 2'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule